// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Supervisor

This block sequences start-up and fault recovery for a regulator controller with one switching output and one linear output. It works only on digital flags from external comparators: supply good (hysteresis is applied outside the block), a shutdown request from the compensation node, the low-side switch state, the switch-node overcurrent comparator, and a linear-feedback undervoltage flag. A single-cycle `tick` marks each switching period and is the timebase for every count.

When the supply is good and no shutdown is requested, the block enables the drivers. It raises two separate reference codes from zero, one per channel, each with its own ramp length. An overcurrent, or a linear-feedback undervoltage that lasts long enough, turns everything off for a fixed number of ticks (hiccup). After that the whole soft-start runs again from zero. Undervoltage detection stays masked until the linear channel's ramp has reached its top. A sticky cause register records which faults tripped and clears on the next rising edge of supply good.

Top module: `softstart_hiccup_supervisor`

## Requirements
- R1: Whenever `supplyOk` is low at a clock edge, the next cycle shows `stateOut` = 0 (off), `runEn` low and both reference codes zero, whatever the previous state.
- R2: From off, with `supplyOk` high and `compShutdown` low, the block enters ramping (`stateOut` = 1) on the next edge and drives `runEn` high. While ramping or running, each channel's counter advances by one per tick until it saturates at all ones. Each reference output is the top `DAC_W` bits of its counter. The two channels have independent lengths (`SW_RAMP_W`, `LDO_RAMP_W`), and both codes are zero whenever `runEn` is low.
- R3: Ramping becomes running (`stateOut` = 2) once both counters have saturated, so both references read all ones.
- R4: `compShutdown` high while ramping or running gives off on the next edge, with both references zero and no fault recorded. The ramps restart from zero once it is released.
- R5: `lowSideOn` and `swBelowLimit` both high while ramping or running gives hiccup (`stateOut` = 3) on the next edge, with `runEn` low, and sets `faultCause` bit 0. `swBelowLimit` alone has no effect.
- R6: `ldoFbLow` is ignored until the linear channel's counter has saturated.
- R7: After the linear ramp has saturated, `ldoFbLow` high on `UV_TICKS` consecutive ticks gives hiccup and sets `faultCause` bit 1. Dropping the flag for any cycle restarts the count.
- R8: Hiccup lasts exactly `HICCUP_TICKS` ticks and ignores `compShutdown` and fault flags. It then goes to off, and the full soft-start restarts on the following edge.
- R9: After reset the state is off and `faultCause` is 0. Cause bits stay set through hiccup and restart, and clear on the next rising edge of `supplyOk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per switching period |
| supplyOk | input | 1 | Supply-good flag (hysteresis applied outside) |
| compShutdown | input | 1 | Shutdown request from the compensation node |
| lowSideOn | input | 1 | Low-side switch is conducting |
| swBelowLimit | input | 1 | Switch-node sense below the overcurrent threshold |
| ldoFbLow | input | 1 | Linear-channel feedback below the undervoltage point |
| runEn | output | 1 | Driver/regulator enable |
| swRef | output | DAC_W | Switching-channel reference code |
| ldoRef | output | DAC_W | Linear-channel reference code |
| stateOut | output | 2 | 0 off, 1 ramping, 2 running, 3 hiccup |
| faultCause | output | 2 | Sticky causes: bit 0 overcurrent, bit 1 linear undervoltage |

## Verification
The assertions take all flags to be already synchronous to `clk`. They also take `tick` to be a one-cycle pulse, so persistence and hiccup windows are counted in ticks rather than clocks. The stimulus changes every input just after the falling clock edge and alternates `tick` every clock. Fault flags are held or pulsed across whole clock cycles, so no flag is ever sampled mid-change. Bursts of `ldoFbLow` shorter than the window are used to show that the persistence count restarts.

// File: rtl/ssh_pkg.sv
package ssh_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RAMP   = 2'd1,
    ST_RUN    = 2'd2,
    ST_HICCUP = 2'd3
  } supState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic rampStep;   // advance both ramps this cycle
    logic rampClear;  // force ramps to zero
    logic uvWatch;    // current state allows undervoltage sensing
    logic uvKeep;     // next state keeps the channel alive
    logic hicStep;    // hiccup timer advances
    logic hicClear;   // hiccup timer held at zero
  } dpStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic swDone;
    logic ldoDone;
    logic uvTrip;
    logic hicDone;
  } dpStatus_t;

endpackage

// File: rtl/ssh_ramp.sv
module ssh_ramp #(
  parameter int CNT_W = 11,
  parameter int DAC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic             clear,
  output logic [DAC_W-1:0] code,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = &cnt;
  assign code = cnt[CNT_W-1 -: DAC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (step && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_RAMP_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> (cnt >= $past(cnt))) else $error("ramp moved down"); // R2

endmodule

// File: rtl/ssh_datapath.sv
module ssh_datapath
  import ssh_pkg::*;
#(
  parameter int SW_RAMP_W    = 11,
  parameter int LDO_RAMP_W   = 11,
  parameter int DAC_W        = 8,
  parameter int UV_TICKS     = 16,
  parameter int HICCUP_TICKS = 2048
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             ldoFbLow,
  input  dpStrobe_t        strobe,
  output dpStatus_t        status,
  output logic [DAC_W-1:0] swRef,
  output logic [DAC_W-1:0] ldoRef
);

  localparam int UV_W  = $clog2(UV_TICKS + 1);
  localparam int HIC_W = $clog2(HICCUP_TICKS + 1);
  localparam int NUM_CH = 2;

  logic [DAC_W-1:0] chCode [NUM_CH];
  logic             chDone [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    localparam int CH_W = (g == 0) ? SW_RAMP_W : LDO_RAMP_W;
    ssh_ramp #(
      .CNT_W(CH_W),
      .DAC_W(DAC_W)
    ) uRamp (
      .clk  (clk),
      .rstN (rstN),
      .step (strobe.rampStep),
      .clear(strobe.rampClear),
      .code (chCode[g]),
      .done (chDone[g])
    );
  end

  assign swRef  = chCode[0];
  assign ldoRef = chCode[1];

  // linear-channel undervoltage persistence
  logic [UV_W-1:0] uvCnt;
  logic            uvSense;
  logic            uvTrip;

  assign uvSense = strobe.uvWatch && chDone[1] && ldoFbLow;
  assign uvTrip  = uvSense && tick && (uvCnt == UV_W'(UV_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uvCnt <= '0;
    end else if (!uvSense || !strobe.uvKeep || uvTrip) begin
      uvCnt <= '0;
    end else if (tick) begin
      uvCnt <= uvCnt + 1'b1;
    end
  end

  // hiccup off-time counter
  logic [HIC_W-1:0] hicCnt;
  logic             hicDone;

  assign hicDone = strobe.hicStep && (hicCnt == HIC_W'(HICCUP_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hicCnt <= '0;
    end else if (strobe.hicClear || hicDone) begin
      hicCnt <= '0;
    end else if (strobe.hicStep) begin
      hicCnt <= hicCnt + 1'b1;
    end
  end

  assign status.swDone  = chDone[0];
  assign status.ldoDone = chDone[1];
  assign status.uvTrip  = uvTrip;
  assign status.hicDone = hicDone;

  AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (uvCnt != '0) |-> chDone[1]) else $error("uv counted during ramp"); // R6
  AST_UV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    uvCnt < UV_W'(UV_TICKS)) else $error("uv window overrun"); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    hicCnt < HIC_W'(HICCUP_TICKS)) else $error("hiccup timer overrun"); // R8

endmodule

// File: rtl/ssh_ctrl.sv
module ssh_ctrl
  import ssh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       supplyOk,
  input  logic       compShutdown,
  input  logic       lowSideOn,
  input  logic       swBelowLimit,
  input  dpStatus_t  status,
  output dpStrobe_t  strobe,
  output supState_t  stateQ,
  output logic [1:0] faultCause
);

  supState_t nextState;
  logic      active;
  logic      nextActive;
  logic      ocHit;
  logic      prevSupply;

  assign active     = (stateQ == ST_RAMP) || (stateQ == ST_RUN);
  assign nextActive = (nextState == ST_RAMP) || (nextState == ST_RUN);
  assign ocHit      = lowSideOn && swBelowLimit;

  always_comb begin
    nextState = stateQ;
    if (!supplyOk) begin
      nextState = ST_OFF;
    end else begin
      case (stateQ)
        ST_OFF: begin
          if (!compShutdown) nextState = ST_RAMP;
        end
        ST_RAMP, ST_RUN: begin
          if (compShutdown) begin
            nextState = ST_OFF;
          end else if (ocHit || status.uvTrip) begin
            nextState = ST_HICCUP;
          end else if ((stateQ == ST_RAMP) && status.swDone && status.ldoDone) begin
            nextState = ST_RUN;
          end
        end
        ST_HICCUP: begin
          if (status.hicDone) nextState = ST_OFF;
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_comb begin
    strobe.rampStep  = active && nextActive && tick;
    strobe.rampClear = !nextActive;
    strobe.uvWatch   = active;
    strobe.uvKeep    = nextActive;
    strobe.hicStep   = (stateQ == ST_HICCUP) && tick;
    strobe.hicClear  = (stateQ != ST_HICCUP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
    end else begin
      stateQ <= nextState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSupply <= 1'b0;
      faultCause <= 2'b00;
    end else begin
      prevSupply <= supplyOk;
      if (supplyOk && !prevSupply) begin
        faultCause <= 2'b00;
      end else if (supplyOk && active && !compShutdown) begin
        if (ocHit)         faultCause[0] <= 1'b1;
        if (status.uvTrip) faultCause[1] <= 1'b1;
      end
    end
  end

  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (stateQ == ST_OFF)) else $error("supply loss ignored"); // R1
  AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && compShutdown && active) |=> (stateQ == ST_OFF)) else $error("shutdown ignored"); // R4
  AST_OC_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && !compShutdown && active && lowSideOn && swBelowLimit)
      |=> (stateQ == ST_HICCUP) && faultCause[0]) else $error("overcurrent missed"); // R5
  AST_HICCUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && (stateQ == ST_HICCUP) && !status.hicDone) |=> (stateQ == ST_HICCUP))
    else $error("hiccup left early"); // R8
  AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyOk) |=> (faultCause == 2'b00)) else $error("cause not cleared"); // R9

endmodule

// File: rtl/softstart_hiccup_supervisor.sv
module softstart_hiccup_supervisor
  import ssh_pkg::*;
#(
  parameter int SW_RAMP_W    = 11,
  parameter int LDO_RAMP_W   = 11,
  parameter int DAC_W        = 8,
  parameter int UV_TICKS     = 16,
  parameter int HICCUP_TICKS = 2048
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             supplyOk,
  input  logic             compShutdown,
  input  logic             lowSideOn,
  input  logic             swBelowLimit,
  input  logic             ldoFbLow,
  output logic             runEn,
  output logic [DAC_W-1:0] swRef,
  output logic [DAC_W-1:0] ldoRef,
  output logic [1:0]       stateOut,
  output logic [1:0]       faultCause
);

  dpStrobe_t strobe;
  dpStatus_t status;
  supState_t stateQ;

  ssh_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .supplyOk    (supplyOk),
    .compShutdown(compShutdown),
    .lowSideOn   (lowSideOn),
    .swBelowLimit(swBelowLimit),
    .status      (status),
    .strobe      (strobe),
    .stateQ      (stateQ),
    .faultCause  (faultCause)
  );

  ssh_datapath #(
    .SW_RAMP_W   (SW_RAMP_W),
    .LDO_RAMP_W  (LDO_RAMP_W),
    .DAC_W       (DAC_W),
    .UV_TICKS    (UV_TICKS),
    .HICCUP_TICKS(HICCUP_TICKS)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .ldoFbLow(ldoFbLow),
    .strobe  (strobe),
    .status  (status),
    .swRef   (swRef),
    .ldoRef  (ldoRef)
  );

  assign runEn    = (stateQ == ST_RAMP) || (stateQ == ST_RUN);
  assign stateOut = stateQ;

  AST_REF_ZERO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (swRef == '0) && (ldoRef == '0)) else $error("reference live while off"); // R2

endmodule

// File: tb/softstart_hiccup_supervisor_test.sv
module softstart_hiccup_supervisor_test;

  localparam int SW_W    = 6;
  localparam int LDO_W   = 5;
  localparam int DW      = 4;
  localparam int UVN     = 4;
  localparam int HICN    = 20;
  localparam int SW_MAX  = (1 << SW_W) - 1;
  localparam int LDO_MAX = (1 << LDO_W) - 1;
  localparam int FULL    = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick;
  logic supplyOk = 1'b0, compShutdown = 1'b0, lowSideOn = 1'b0;
  logic swBelowLimit = 1'b0, ldoFbLow = 1'b0;
  logic runEn;
  logic [DW-1:0] swRef, ldoRef;
  logic [1:0] stateOut, faultCause;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  softstart_hiccup_supervisor #(
    .SW_RAMP_W(SW_W), .LDO_RAMP_W(LDO_W), .DAC_W(DW),
    .UV_TICKS(UVN), .HICCUP_TICKS(HICN)
  ) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .supplyOk(supplyOk),
    .compShutdown(compShutdown), .lowSideOn(lowSideOn),
    .swBelowLimit(swBelowLimit), .ldoFbLow(ldoFbLow), .runEn(runEn),
    .swRef(swRef), .ldoRef(ldoRef), .stateOut(stateOut), .faultCause(faultCause)
  );

  always @(negedge clk or negedge rstN) begin
    if (!rstN) tick <= 1'b0;
    else       tick <= !tick;
  end

  // behavioural reference model
  int mState, mSw, mLdo, mUv, mHic, mCause;
  bit mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mSw = 0; mLdo = 0; mUv = 0; mHic = 0; mCause = 0; mPrev = 0;
    end else begin
      bit act, nAct, oc, trip, hend;
      int nxt;
      act  = (mState == 1) || (mState == 2);
      oc   = lowSideOn && swBelowLimit;
      trip = act && (mLdo == LDO_MAX) && ldoFbLow && tick && (mUv == UVN - 1);
      hend = (mState == 3) && tick && (mHic == HICN - 1);
      nxt  = mState;
      if (!supplyOk) nxt = 0;
      else if (mState == 0) begin
        if (!compShutdown) nxt = 1;
      end else if (act) begin
        if (compShutdown) nxt = 0;
        else if (oc || trip) nxt = 3;
        else if (mState == 1 && mSw == SW_MAX && mLdo == LDO_MAX) nxt = 2;
      end else if (hend) nxt = 0;
      nAct = (nxt == 1) || (nxt == 2);
      if (supplyOk && !mPrev) mCause = 0;
      else if (supplyOk && act && !compShutdown) begin
        if (oc)   mCause = mCause | 1;
        if (trip) mCause = mCause | 2;
      end
      if (!(act && nAct && (mLdo == LDO_MAX) && ldoFbLow) || trip) mUv = 0;
      else if (tick) mUv = mUv + 1;
      if (mState != 3 || hend) mHic = 0;
      else if (tick) mHic = mHic + 1;
      if (!nAct) begin mSw = 0; mLdo = 0; end
      else if (act && tick) begin
        if (mSw < SW_MAX) mSw = mSw + 1;
        if (mLdo < LDO_MAX) mLdo = mLdo + 1;
      end
      mPrev = supplyOk;
      mState = nxt;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R3", "state vs model", int'(stateOut), mState);
      check("R2", "runEn vs model", int'(runEn), int'((mState == 1) || (mState == 2)));
      check("R2", "swRef vs model", int'(swRef), mSw >> (SW_W - DW));
      check("R2", "ldoRef vs model", int'(ldoRef), mLdo >> (LDO_W - DW));
      check("R9", "faultCause vs model", int'(faultCause), mCause);
    end
  end

  task automatic cycles(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic waitState(input int s, input int maxCyc, input string req);
    int k = 0;
    while (int'(stateOut) != s && k < maxCyc) begin
      cycles(1);
      k++;
    end
    check(req, "state reached", int'(stateOut), s);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failCnt++;
      $display("FAIL R2 watchdog expired: actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    int hicTicks;
    int iter;
    cycles(3);
    rstN = 1'b1;
    cycles(2);
    check("R9", "reset state", int'(stateOut), 0);
    check("R9", "reset cause", int'(faultCause), 0);
    check("R1", "runEn low without supply", int'(runEn), 0);

    // start-up with undervoltage flag held during the ramp
    supplyOk = 1'b1;
    ldoFbLow = 1'b1;
    cycles(1);
    check("R2", "enter ramp", int'(stateOut), 1);
    check("R2", "runEn in ramp", int'(runEn), 1);
    cycles(20);
    check("R6", "uv masked keeps ramp", int'(stateOut), 1);
    check("R6", "uv masked no cause", int'(faultCause), 0);
    ldoFbLow = 1'b0;
    while (int'(ldoRef) != FULL) cycles(1);
    check("R2", "independent ramps: sw below full", int'(swRef < FULL), 1);
    waitState(2, 300, "R3");
    check("R3", "sw ref full", int'(swRef), FULL);
    check("R3", "ldo ref full", int'(ldoRef), FULL);

    // switch-node flag without low-side conduction
    swBelowLimit = 1'b1;
    cycles(4);
    check("R5", "sense alone ignored", int'(stateOut), 2);
    swBelowLimit = 1'b0;

    // short undervoltage burst
    ldoFbLow = 1'b1;
    cycles(5);
    ldoFbLow = 1'b0;
    cycles(2);
    check("R7", "short burst ignored", int'(stateOut), 2);
    check("R7", "short burst no cause", int'(faultCause), 0);

    // persistent undervoltage
    ldoFbLow = 1'b1;
    waitState(3, 40, "R7");
    ldoFbLow = 1'b0;
    check("R7", "uv cause bit", int'(faultCause), 2);
    check("R5", "runEn low in hiccup", int'(runEn), 0);
    check("R8", "refs zero in hiccup", int'(swRef) + int'(ldoRef), 0);
    hicTicks = 0;
    iter = 0;
    while (int'(stateOut) == 3 && iter < 200) begin
      if (iter == 3) begin compShutdown = 1'b1; lowSideOn = 1'b1; swBelowLimit = 1'b1; end
      if (iter == 8) begin compShutdown = 1'b0; lowSideOn = 1'b0; swBelowLimit = 1'b0; end
      if (tick) hicTicks++;
      cycles(1);
      iter++;
    end
    check("R8", "hiccup tick count", hicTicks, HICN);
    check("R8", "off after hiccup", int'(stateOut), 0);
    cycles(1);
    check("R8", "restart ramp", int'(stateOut), 1);
    check("R9", "cause sticky", int'(faultCause), 2);

    // overcurrent during ramp
    cycles(3);
    lowSideOn = 1'b1;
    swBelowLimit = 1'b1;
    cycles(1);
    lowSideOn = 1'b0;
    swBelowLimit = 1'b0;
    check("R5", "oc enters hiccup", int'(stateOut), 3);
    check("R5", "oc cause bit", int'(faultCause), 3);
    check("R5", "runEn low after oc", int'(runEn), 0);

    // supply loss overrides hiccup, rising edge clears causes
    cycles(3);
    supplyOk = 1'b0;
    cycles(1);
    check("R1", "supply loss to off", int'(stateOut), 0);
    check("R9", "cause held while off", int'(faultCause), 3);
    cycles(3);
    supplyOk = 1'b1;
    cycles(1);
    check("R9", "cause cleared on rise", int'(faultCause), 0);
    check("R2", "ramp after supply", int'(stateOut), 1);

    // compensation shutdown
    waitState(2, 300, "R3");
    compShutdown = 1'b1;
    cycles(1);
    check("R4", "shutdown to off", int'(stateOut), 0);
    check("R4", "shutdown refs zero", int'(swRef) + int'(ldoRef), 0);
    check("R4", "shutdown runEn", int'(runEn), 0);
    cycles(3);
    check("R4", "held off", int'(stateOut), 0);
    check("R4", "no cause", int'(faultCause), 0);
    compShutdown = 1'b0;
    cycles(1);
    check("R4", "released ramp", int'(stateOut), 1);
    cycles(4);
    check("R4", "ramp from zero", int'(swRef), 0);

    // supply loss while running
    waitState(2, 300, "R3");
    supplyOk = 1'b0;
    cycles(1);
    check("R1", "supply loss in run", int'(stateOut), 0);
    check("R1", "refs zero", int'(swRef) + int'(ldoRef), 0);

    cycles(2);
    finished = 1;
    summary();
    $finish;
  end

endmodule